// File: doc/BRIEF.md
# 64-bit Integer Add/Subtract Unit with Carry

This block is the add/subtract datapath of a fixed-point execution pipe. It is purely combinational. A decoded operation code picks the two addends and the carry-in from these sources: two register operands, a 16-bit immediate, the next-instruction address, the carry flag, and an alternate flag. A single 64-bit adder forms the sum. Subtraction is always "complement the first operand, add the second, add one", and the extended forms feed a flag in place of that constant one.

The unit returns the 64-bit result and the updated carry and alternate flags, each with a write strobe. It also returns a signed-overflow flag, which is active only when the overflow-enable bit is set, and a three-way signed compare of the result, which is driven only when the record bit is set. Operand fetch, decoding and any sticky overflow bookkeeping belong to the surrounding pipe.

Top module: `addsub_unit`

## Requirements
- R1: Operation codes: 0 add, 1 subtract-from, 2 add carrying, 3 subtract-from carrying, 4 add extended, 5 subtract-from extended, 6 add-to-minus-one, 7 subtract-from-minus-one, 8 add-to-zero, 9 subtract-from-zero, 10 negate, 11 add immediate, 12 add shifted immediate, 13 PC-relative shifted add, 14 add immediate carrying, 15 subtract-from immediate carrying, 16 add extended on the alternate flag. Codes 0 and 2 return a+b.
- R2: Codes 1 and 3 return ~a + b + 1, so the result equals b - a modulo 2^64.
- R3: For codes 11 and 12, a register index of zero makes the first addend zero. Code 14 always uses a.
- R4: The immediate is sign-extended to 64 bits. For codes 12 and 13 it is first shifted left by 16. Code 13 adds the shifted immediate to the next-instruction address.
- R5: Codes 4, 5, 6, 7, 8 and 9 use the carry flag input as the carry-in. For these codes the second addend is b, b, all ones, all ones, zero and zero, and the complement of a is used for the odd codes.
- R6: Code 16 returns a + b + alt_i. It drives its carry-out onto alt_o with alt_we_o high, and holds ca_we_o low. For all other codes alt_we_o is low and alt_o equals alt_i.
- R7: ca_we_o is high for codes 2 through 9, 14 and 15, and for those codes ca_o is the carry out of bit 63. For all other codes ca_we_o is low and ca_o equals ca_i.
- R8: ov_o is high only when oe_i is high, the code is not 16, and the two addends share a sign that differs from the sign of the result.
- R9: Code 10 returns ~a + 1. Negating zero gives zero, and negating the most negative value gives that value with ov_o set when oe_i is high.
- R10: When rec_i is high, cmp_o = {negative, positive, zero} of the signed result with exactly one bit set. When rec_i is low, cmp_o is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 64 | First register operand |
| b_i | input | 64 | Second register operand |
| imm_i | input | 16 | Immediate or displacement |
| ra_idx_i | input | 5 | Register index of the first operand |
| nia_i | input | 64 | Next-instruction address |
| ca_i | input | 1 | Current carry flag |
| alt_i | input | 1 | Current alternate carry flag |
| oe_i | input | 1 | Overflow enable |
| rec_i | input | 1 | Record enable for the compare flags |
| result_o | output | 64 | Sum |
| ca_o | output | 1 | Next carry flag |
| ca_we_o | output | 1 | Carry flag write strobe |
| alt_o | output | 1 | Next alternate flag |
| alt_we_o | output | 1 | Alternate flag write strobe |
| ov_o | output | 1 | Signed overflow, gated by oe_i |
| cmp_o | output | 3 | {negative, positive, zero} when rec_i is high |

## Verification
The embedded assertions check, for every input combination, these invariants:
- the compare flags are one-hot under record and silent without it;
- overflow is suppressed without enable;
- only the alternate-carry code writes the alternate flag;
- a zero index turns the immediate adds into a pure sign-extended immediate;
- negating zero gives zero.

The numeric value of every sum and carry for each code cannot be shown by an invariant. Neither can the choice of carry source, the shift of the immediate, or overflow at the sign boundaries. These are shown only by the bench's directed corner cases and its randomized operations compared against a reference model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned IMM_W = 16;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned OP_W  = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD     = 5'd0,
    OP_SUBF    = 5'd1,
    OP_ADDC    = 5'd2,
    OP_SUBFC   = 5'd3,
    OP_ADDE    = 5'd4,
    OP_SUBFE   = 5'd5,
    OP_ADDME   = 5'd6,
    OP_SUBFME  = 5'd7,
    OP_ADDZE   = 5'd8,
    OP_SUBFZE  = 5'd9,
    OP_NEG     = 5'd10,
    OP_ADDI    = 5'd11,
    OP_ADDIS   = 5'd12,
    OP_ADDPCIS = 5'd13,
    OP_ADDIC   = 5'd14,
    OP_SUBFIC  = 5'd15,
    OP_ADDEX   = 5'd16
  } op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_CA   = 2'd2,
    CIN_ALT  = 2'd3
  } cin_e;
endpackage

// File: rtl/addsub_opsel.sv
module addsub_opsel
  import addsub_pkg::*;
#(
  parameter int unsigned W      = XLEN,
  parameter int unsigned IW     = IMM_W,
  parameter int unsigned SHIFT  = 16,
  parameter int unsigned IDXW   = IDX_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [IW-1:0]   imm_i,
  input  logic [IDXW-1:0] ra_idx_i,
  input  logic [W-1:0]    nia_i,
  input  logic            ca_i,
  input  logic            alt_i,
  output logic [W-1:0]    x_o,
  output logic [W-1:0]    y_o,
  output logic            cin_o,
  output logic            ca_we_o,
  output logic            alt_we_o,
  output logic            ov_ok_o
);
  localparam int unsigned EXT_W  = W - IW;
  localparam int unsigned EXTS_W = W - IW - SHIFT;

  logic [W-1:0] simm, shimm, a_or_zero;
  cin_e         cin_sel;
  op_e          op;

  assign op        = op_e'(op_i);
  assign simm      = {{EXT_W{imm_i[IW-1]}}, imm_i};
  assign shimm     = {{EXTS_W{imm_i[IW-1]}}, imm_i, {SHIFT{1'b0}}};
  assign a_or_zero = (ra_idx_i == '0) ? '0 : a_i;

  always_comb begin
    x_o      = a_i;
    y_o      = b_i;
    cin_sel  = CIN_ZERO;
    ca_we_o  = 1'b0;
    alt_we_o = 1'b0;
    ov_ok_o  = 1'b1;
    unique case (op)
      OP_ADD:     ;
      OP_ADDC:    ca_we_o = 1'b1;
      OP_SUBF:    begin x_o = ~a_i; cin_sel = CIN_ONE; end
      OP_SUBFC:   begin x_o = ~a_i; cin_sel = CIN_ONE; ca_we_o = 1'b1; end
      OP_ADDE:    begin cin_sel = CIN_CA; ca_we_o = 1'b1; end
      OP_SUBFE:   begin x_o = ~a_i; cin_sel = CIN_CA; ca_we_o = 1'b1; end
      OP_ADDME:   begin y_o = '1; cin_sel = CIN_CA; ca_we_o = 1'b1; end
      OP_SUBFME:  begin x_o = ~a_i; y_o = '1; cin_sel = CIN_CA; ca_we_o = 1'b1; end
      OP_ADDZE:   begin y_o = '0; cin_sel = CIN_CA; ca_we_o = 1'b1; end
      OP_SUBFZE:  begin x_o = ~a_i; y_o = '0; cin_sel = CIN_CA; ca_we_o = 1'b1; end
      OP_NEG:     begin x_o = ~a_i; y_o = '0; cin_sel = CIN_ONE; end
      OP_ADDI:    begin x_o = a_or_zero; y_o = simm; end
      OP_ADDIS:   begin x_o = a_or_zero; y_o = shimm; end
      OP_ADDPCIS: begin x_o = nia_i; y_o = shimm; end
      OP_ADDIC:   begin y_o = simm; ca_we_o = 1'b1; end
      OP_SUBFIC:  begin x_o = ~a_i; y_o = simm; cin_sel = CIN_ONE; ca_we_o = 1'b1; end
      OP_ADDEX:   begin cin_sel = CIN_ALT; alt_we_o = 1'b1; ov_ok_o = 1'b0; end
      default:    ;
    endcase
  end

  always_comb begin
    unique case (cin_sel)
      CIN_ZERO: cin_o = 1'b0;
      CIN_ONE:  cin_o = 1'b1;
      CIN_CA:   cin_o = ca_i;
      CIN_ALT:  cin_o = alt_i;
      default:  cin_o = 1'b0;
    endcase
  end

  always_comb begin
    assert (!(ca_we_o && alt_we_o)) else $error("AST_ONE_FLAG_WRITER"); // R6
    assert (!(op == OP_ADDPCIS) || (x_o == nia_i)) else $error("AST_PC_BASE"); // R4
  end
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
  parameter int unsigned W  = 64,
  parameter int unsigned CH = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ov_o
);
  localparam int unsigned NCH = W / CH;

  logic [NCH:0] carry;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    logic [CH:0] part;
    assign part = {1'b0, x_i[g*CH +: CH]} + {1'b0, y_i[g*CH +: CH]} + {{CH{1'b0}}, carry[g]};
    assign sum_o[g*CH +: CH] = part[CH-1:0];
    assign carry[g+1]        = part[CH];
  end

  assign cout_o = carry[NCH];
  // same-sign addends, opposite-sign sum
  assign ov_o   = (x_i[W-1] == y_i[W-1]) && (sum_o[W-1] != x_i[W-1]);

  always_comb begin
    assert (!((x_i == '0) && (y_i == '0)) || (sum_o == {{(W-1){1'b0}}, cin_i} && !cout_o))
      else $error("AST_ZERO_ADDENDS"); // R1
    assert (!((x_i == '1) && (y_i == '0) && cin_i) || (sum_o == '0 && cout_o))
      else $error("AST_WRAP_CARRY"); // R7
  end
endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] res_i,
  input  logic         rec_i,
  output logic [2:0]   cmp_o
);
  logic is_neg, is_zero, is_pos;

  assign is_neg  = res_i[W-1];
  assign is_zero = (res_i == '0);
  assign is_pos  = !is_neg && !is_zero;
  assign cmp_o   = rec_i ? {is_neg, is_pos, is_zero} : 3'b000;
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  input  logic [XLEN-1:0]  nia_i,
  input  logic             ca_i,
  input  logic             alt_i,
  input  logic             oe_i,
  input  logic             rec_i,
  output logic [XLEN-1:0]  result_o,
  output logic             ca_o,
  output logic             ca_we_o,
  output logic             alt_o,
  output logic             alt_we_o,
  output logic             ov_o,
  output logic [2:0]       cmp_o
);
  localparam int unsigned CHUNK = 16;

  logic [XLEN-1:0] x, y;
  logic            cin, cout, ov_raw, ov_ok;

  addsub_opsel #(.W(XLEN), .IW(IMM_W), .SHIFT(16), .IDXW(IDX_W)) u_opsel (
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .imm_i    (imm_i),
    .ra_idx_i (ra_idx_i),
    .nia_i    (nia_i),
    .ca_i     (ca_i),
    .alt_i    (alt_i),
    .x_o      (x),
    .y_o      (y),
    .cin_o    (cin),
    .ca_we_o  (ca_we_o),
    .alt_we_o (alt_we_o),
    .ov_ok_o  (ov_ok)
  );

  addsub_adder #(.W(XLEN), .CH(CHUNK)) u_adder (
    .x_i    (x),
    .y_i    (y),
    .cin_i  (cin),
    .sum_o  (result_o),
    .cout_o (cout),
    .ov_o   (ov_raw)
  );

  addsub_cmp #(.W(XLEN)) u_cmp (
    .res_i (result_o),
    .rec_i (rec_i),
    .cmp_o (cmp_o)
  );

  assign ca_o  = ca_we_o  ? cout : ca_i;
  assign alt_o = alt_we_o ? cout : alt_i;
  assign ov_o  = oe_i && ov_ok && ov_raw;

  always_comb begin
    assert (!rec_i || $onehot(cmp_o)) else $error("AST_CMP_ONEHOT"); // R10
    assert (rec_i || cmp_o == 3'b000) else $error("AST_CMP_QUIET"); // R10
    assert (oe_i || !ov_o) else $error("AST_NO_OVERFLOW"); // R8
    assert (!alt_we_o || (op_i == OP_ADDEX && !ca_we_o)) else $error("AST_ALT_ONLY"); // R6
    assert (!(op_i == OP_ADDI && ra_idx_i == '0) || result_o == {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i})
      else $error("AST_ZERO_IDX"); // R3
    assert (!(op_i == OP_NEG && a_i == '0) || (result_o == '0 && !ca_we_o))
      else $error("AST_NEG_ZERO"); // R9
  end
endmodule

// File: tb/addsub_unit_tb.sv
module addsub_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_i;
  logic [63:0] a_i, b_i, nia_i, result_o;
  logic [15:0] imm_i;
  logic [4:0]  ra_idx_i;
  logic        ca_i, alt_i, oe_i, rec_i;
  logic        ca_o, ca_we_o, alt_o, alt_we_o, ov_o;
  logic [2:0]  cmp_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addsub_unit u_dut (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .ra_idx_i(ra_idx_i),
    .nia_i(nia_i), .ca_i(ca_i), .alt_i(alt_i), .oe_i(oe_i), .rec_i(rec_i),
    .result_o(result_o), .ca_o(ca_o), .ca_we_o(ca_we_o), .alt_o(alt_o),
    .alt_we_o(alt_we_o), .ov_o(ov_o), .cmp_o(cmp_o)
  );

  typedef struct packed {
    logic [63:0] res;
    logic        ca;
    logic        ca_we;
    logic        alt;
    logic        alt_we;
    logic        ov;
    logic [2:0]  cmp;
  } exp_t;

  function automatic exp_t model(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                                 input logic [15:0] imm, input logic [4:0] idx, input logic [63:0] nia,
                                 input logic ca, input logic alt, input logic oe, input logic rec);
    exp_t e;
    logic [63:0] p, q, s16, sh;
    logic        c, wca, walt, ovok;
    logic [64:0] full;
    s16  = 64'(signed'(imm));
    sh   = 64'(signed'({imm, 16'h0}));
    p = a; q = b; c = 1'b0; wca = 1'b0; walt = 1'b0; ovok = 1'b1;
    case (op)
      5'd0:  ;
      5'd1:  begin p = ~a; c = 1'b1; end
      5'd2:  wca = 1'b1;
      5'd3:  begin p = ~a; c = 1'b1; wca = 1'b1; end
      5'd4:  begin c = ca; wca = 1'b1; end
      5'd5:  begin p = ~a; c = ca; wca = 1'b1; end
      5'd6:  begin q = '1; c = ca; wca = 1'b1; end
      5'd7:  begin p = ~a; q = '1; c = ca; wca = 1'b1; end
      5'd8:  begin q = '0; c = ca; wca = 1'b1; end
      5'd9:  begin p = ~a; q = '0; c = ca; wca = 1'b1; end
      5'd10: begin p = ~a; q = '0; c = 1'b1; end
      5'd11: begin p = (idx == 0) ? 64'h0 : a; q = s16; end
      5'd12: begin p = (idx == 0) ? 64'h0 : a; q = sh; end
      5'd13: begin p = nia; q = sh; end
      5'd14: begin q = s16; wca = 1'b1; end
      5'd15: begin p = ~a; q = s16; c = 1'b1; wca = 1'b1; end
      default: begin c = alt; walt = 1'b1; ovok = 1'b0; end
    endcase
    full     = {1'b0, p} + {1'b0, q} + 65'(c);
    e.res    = full[63:0];
    e.ca_we  = wca;
    e.ca     = wca ? full[64] : ca;
    e.alt_we = walt;
    e.alt    = walt ? full[64] : alt;
    e.ov     = oe && ovok && ($signed(p) < 0) == ($signed(q) < 0) && ($signed(e.res) < 0) != ($signed(p) < 0);
    if (!rec) e.cmp = 3'b000;
    else if ($signed(e.res) < 0) e.cmp = 3'b100;
    else if (e.res == 0) e.cmp = 3'b001;
    else e.cmp = 3'b010;
    return e;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd2:                     return "R1";
      5'd1, 5'd3:                     return "R2";
      5'd11, 5'd14:                   return "R3";
      5'd12, 5'd13:                   return "R4";
      5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9: return "R5";
      5'd10:                          return "R9";
      5'd15:                          return "R4";
      default:                        return "R6";
    endcase
  endfunction

  task automatic run(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                     input logic [15:0] imm, input logic [4:0] idx, input logic [63:0] nia,
                     input logic ca, input logic alt, input logic oe, input logic rec);
    exp_t e;
    string r;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; imm_i = imm; ra_idx_i = idx; nia_i = nia;
    ca_i = ca; alt_i = alt; oe_i = oe; rec_i = rec;
    #2;
    e = model(op, a, b, imm, idx, nia, ca, alt, oe, rec);
    r = req_of(op);
    chk(r, "result", result_o, e.res);
    chk("R7", "ca_we", 64'(ca_we_o), 64'(e.ca_we));
    chk("R7", "ca", 64'(ca_o), 64'(e.ca));
    chk("R6", "alt_we", 64'(alt_we_o), 64'(e.alt_we));
    chk("R6", "alt", 64'(alt_o), 64'(e.alt));
    chk("R8", "ov", 64'(ov_o), 64'(e.ov));
    chk("R10", "cmp", 64'(cmp_o), 64'(e.cmp));
  endtask

  task automatic direct(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    chk(req, what, act, exp);
  endtask

  initial begin
    logic [63:0] ra, rb;
    void'($urandom(32'h5eed_1234));
    op_i = '0; a_i = '0; b_i = '0; imm_i = '0; ra_idx_i = '0; nia_i = '0;
    ca_i = 1'b0; alt_i = 1'b0; oe_i = 1'b0; rec_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // idle state with zero inputs
    direct("R1", "idle result", result_o, 64'h0);
    direct("R10", "idle cmp", 64'(cmp_o), 64'h0);

    // R1 add and add carrying with carry out
    run(5'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 5'd3, 64'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    direct("R1", "addc wrap", result_o, 64'h0);
    direct("R7", "addc carry", 64'(ca_o), 64'h1);
    // R2 subtract-from, b - a
    run(5'd1, 64'd7, 64'd5, 16'h0, 5'd1, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    direct("R2", "subf", result_o, 64'hFFFF_FFFF_FFFF_FFFE);
    direct("R10", "subf neg cmp", 64'(cmp_o), 64'h4);
    run(5'd3, 64'd5, 64'd5, 16'h0, 5'd1, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    direct("R7", "subfc equal carry", 64'(ca_o), 64'h1);
    direct("R10", "zero cmp", 64'(cmp_o), 64'h1);
    // R3 zero index
    run(5'd11, 64'h1234, 64'h0, 16'h8000, 5'd0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    direct("R3", "addi idx0", result_o, 64'hFFFF_FFFF_FFFF_8000);
    run(5'd14, 64'h1234, 64'h0, 16'h0001, 5'd0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    direct("R3", "addic uses a", result_o, 64'h1235);
    // R4 shifted and PC forms
    run(5'd12, 64'h10, 64'h0, 16'hFFFF, 5'd2, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    direct("R4", "addis neg", result_o, 64'hFFFF_FFFF_FFFF_0010);
    run(5'd13, 64'hDEAD, 64'h0, 16'h0002, 5'd0, 64'h4000, 1'b0, 1'b0, 1'b0, 1'b0);
    direct("R4", "pc shifted", result_o, 64'h2_4000);
    // R5 extended with carry in
    run(5'd4, 64'd10, 64'd20, 16'h0, 5'd1, 64'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    direct("R5", "adde ca", result_o, 64'd31);
    run(5'd6, 64'd0, 64'd0, 16'h0, 5'd1, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    direct("R5", "addme", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
    direct("R7", "addme no carry", 64'(ca_o), 64'h0);
    // R6 alternate flag
    run(5'd16, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0, 5'd1, 64'h0, 1'b0, 1'b1, 1'b1, 1'b0);
    direct("R6", "addex alt carry", 64'(alt_o), 64'h1);
    direct("R6", "addex ca untouched", 64'(ca_we_o), 64'h0);
    direct("R8", "addex no ov", 64'(ov_o), 64'h0);
    // R8 overflow gating
    run(5'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 5'd1, 64'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    direct("R8", "ov with oe", 64'(ov_o), 64'h1);
    run(5'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 5'd1, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    direct("R8", "ov without oe", 64'(ov_o), 64'h0);
    direct("R10", "no record", 64'(cmp_o), 64'h0);
    // R9 negate corners
    run(5'd10, 64'h0, 64'h0, 16'h0, 5'd1, 64'h0, 1'b1, 1'b0, 1'b1, 1'b1);
    direct("R9", "neg zero", result_o, 64'h0);
    run(5'd10, 64'h8000_0000_0000_0000, 64'h0, 16'h0, 5'd1, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    direct("R9", "neg min", result_o, 64'h8000_0000_0000_0000);
    direct("R9", "neg min ov", 64'(ov_o), 64'h1);

    for (int i = 0; i < 400; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (($urandom % 8) == 0) ra = ($urandom % 2) ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
      if (($urandom % 8) == 0) rb = ($urandom % 2) ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0;
      run(5'($urandom % 17), ra, rb, 16'($urandom), 5'($urandom % 4), {$urandom, $urandom},
          1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule